// File: doc/BRIEF.md
# Serial NOR Flash Read DMA Engine

The engine copies a block of data from a serial NOR flash into system memory without processor involvement. Software writes the flash source address, a destination start address and an exclusive destination end address, picks the lane mode and the read opcode, then sets the go bit. The engine selects the chip, sends the opcode and the address, inserts the dummy clocks that the lane mode requires, and then clocks in data. It packs the received bytes into 128-bit beats and presents each beat on a plain write-strobe memory port.

When the last beat has been written, the go bit drops back to zero and a done status bit is set. The interrupt line follows that status bit through an enable mask, and software clears the status by writing a one to it. A request whose end address does not exceed its start address finishes at once without touching the flash. An abort bit stops any transfer in progress and returns the engine to idle.

The serial clock runs at half the system clock. Each serial clock spans two system cycles: the engine changes outputs on the falling edge and samples inputs on the rising edge.

Top module: `nor_dma_reader`

## Requirements
- R1: After reset every register reads zero. Registers sit at byte offsets 0x00 control, 0x04 lane mode, 0x08 opcode, 0x0C flash address, 0x10 destination start, 0x14 destination end, 0x18 status and 0x1C interrupt enable. The three address registers always read back with their low 4 bits cleared.
- R2: Writing 1 to control bit 0 starts a transfer. That bit then reads 1 until the final beat has been written, after which it reads 0.
- R3: Chip select stays low for the whole transfer, and the serial clock stays low while it is high. The opcode goes out first, MSB first, on io0. The address follows MSB first: 4 bytes when mode bit 4 is set, otherwise the low 3 bytes of the flash address. On 2 lanes the earlier bit goes on io1, and on 4 lanes the earliest bit goes on io3.
- R4: With single-lane data, the engine inserts 8 dummy clocks when the opcode is 0x0B and none otherwise. With 2-lane or 4-lane data, it inserts 8 dummy clocks for a single-lane address, 4 for a 2-lane address and 6 for a 4-lane address.
- R5: Mode bit 2 selects 4-lane data and takes priority over bit 0, which selects 2-lane data. Address lanes equal the data lanes only when the matching address bit is also set: bit 3 with bit 2, or bit 1 with bit 0. Data bits arrive MSB first, on io1 for a single lane, on io1:io0 for 2 lanes, and on io3:io0 for 4 lanes.
- R6: Received bytes fill 128-bit beats, with the first byte in bits 7:0. The first beat goes to the destination start address, and each later beat goes 16 bytes higher. Exactly (end - start)/16 beats are written.
- R7: Completion sets status bit 7. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: The irq output is high exactly when status bit 7 and enable bit 7 are both set.
- R9: A start with end <= start sets status bit 7 and leaves control bit 0 at 0. It writes no beat and leaves chip select high.
- R10: Writing 1 to control bit 1 ends any transfer. After the next clock edge, chip select is high, control bit 0 reads 0, no further beat is written and no status is set. A later transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Masked done interrupt |
| spi_sck | output | 1 | Serial flash clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Serial data out, io3..io0 |
| spi_io_oe | output | 4 | Output enable per io line |
| spi_io_in | input | 4 | Serial data in, io3..io0 |
| mem_we | output | 1 | Memory beat write strobe |
| mem_addr | output | ADDR_W | Memory beat byte address |
| mem_wdata | output | 8*BEAT_BYTES | Memory beat data |

## Verification
The assertions rely on software not rewriting the lane mode, opcode or address registers while a transfer runs. They also rely on the flash driving io lines only after the engine has released them. The stimulus changes configuration registers only while the engine is idle, except for the abort write. The flash model drives its data lines only from the negative edge of the serial clock that follows the last dummy clock. Every address the stimulus programs into a transfer is 16-byte aligned, so the check that beats land on aligned addresses follows from those inputs.

// File: rtl/ndr_pkg.sv
package ndr_pkg;

    localparam int FA_W  = 32;
    localparam int OPC_W = 8;
    localparam int SR_W  = OPC_W + FA_W;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_MODE  = 8'h04;
    localparam logic [7:0] OFS_OPC   = 8'h08;
    localparam logic [7:0] OFS_FADDR = 8'h0C;
    localparam logic [7:0] OFS_DST   = 8'h10;
    localparam logic [7:0] OFS_END   = 8'h14;
    localparam logic [7:0] OFS_STAT  = 8'h18;
    localparam logic [7:0] OFS_INTEN = 8'h1C;

    localparam int CTRL_GO    = 0;
    localparam int CTRL_ABORT = 1;
    localparam int DONE_BIT   = 7;

    localparam int BM_DUAL_RD = 0;
    localparam int BM_DUAL_AD = 1;
    localparam int BM_QUAD_RD = 2;
    localparam int BM_QUAD_AD = 3;
    localparam int BM_WIDE_AD = 4;

    localparam logic [7:0] OPC_FAST = 8'h0B;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    // log2 of the number of data lanes
    function automatic logic [1:0] data_lanes_log(input logic [4:0] m);
        if (m[BM_QUAD_RD]) return 2'd2;
        if (m[BM_DUAL_RD]) return 2'd1;
        return 2'd0;
    endfunction

    // log2 of the number of address lanes
    function automatic logic [1:0] addr_lanes_log(input logic [4:0] m);
        if (m[BM_QUAD_RD]) return m[BM_QUAD_AD] ? 2'd2 : 2'd0;
        if (m[BM_DUAL_RD]) return m[BM_DUAL_AD] ? 2'd1 : 2'd0;
        return 2'd0;
    endfunction

    function automatic logic [3:0] dummy_clocks(input logic [1:0] dl,
                                                input logic [1:0] al,
                                                input logic [7:0] opc);
        if (dl != 2'd0) begin
            case (al)
                2'd0:    return 4'd8;
                2'd1:    return 4'd4;
                default: return 4'd6;
            endcase
        end
        return (opc == OPC_FAST) ? 4'd8 : 4'd0;
    endfunction

endpackage

// File: rtl/ndr_regs.sv
module ndr_regs
    import ndr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done_i,
    output logic              launch_o,
    output logic              abort_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic [4:0]        mode_o,
    output logic [7:0]        opc_o,
    output logic [FA_W-1:0]   faddr_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [ADDR_W-1:0] dend_o
);

    localparam int LSB_W = $clog2(BEAT_BYTES);

    typedef struct packed {
        logic              busy;
        logic              launch;
        logic [4:0]        mode;
        logic [7:0]        opc;
        logic [FA_W-1:0]   fa;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] dend;
        logic              stat;
        logic              en;
    } regs_t;

    regs_t q, d;
    logic  zero_done;
    logic  ctrl_wr;

    assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
    assign abort_o = ctrl_wr && reg_wdata[CTRL_ABORT];

    always_comb begin
        d         = q;
        d.launch  = 1'b0;
        zero_done = 1'b0;
        if (done_i) d.busy = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    if (reg_wdata[CTRL_ABORT]) begin
                        d.busy = 1'b0;
                    end else if (reg_wdata[CTRL_GO] && !q.busy) begin
                        if (q.dend > q.dst) begin
                            d.busy   = 1'b1;
                            d.launch = 1'b1;
                        end else begin
                            zero_done = 1'b1;
                        end
                    end
                end
                OFS_MODE:  d.mode = reg_wdata[4:0];
                OFS_OPC:   d.opc  = reg_wdata[7:0];
                OFS_FADDR: d.fa   = {reg_wdata[FA_W-1:LSB_W], {LSB_W{1'b0}}};
                OFS_DST:   d.dst  = {reg_wdata[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
                OFS_END:   d.dend = {reg_wdata[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
                OFS_STAT:  if (reg_wdata[DONE_BIT]) d.stat = 1'b0;
                OFS_INTEN: d.en   = reg_wdata[DONE_BIT];
                default: ;
            endcase
        end
        if ((done_i && !abort_o) || zero_done) d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata[CTRL_GO]  = q.busy;
            OFS_MODE:  reg_rdata[4:0]      = q.mode;
            OFS_OPC:   reg_rdata[7:0]      = q.opc;
            OFS_FADDR: reg_rdata           = q.fa;
            OFS_DST:   reg_rdata           = 32'(q.dst);
            OFS_END:   reg_rdata           = 32'(q.dend);
            OFS_STAT:  reg_rdata[DONE_BIT] = q.stat;
            OFS_INTEN: reg_rdata[DONE_BIT] = q.en;
            default: ;
        endcase
    end

    assign launch_o = q.launch;
    assign busy_o   = q.busy;
    assign irq_o    = q.stat & q.en;
    assign mode_o   = q.mode;
    assign opc_o    = q.opc;
    assign faddr_o  = q.fa;
    assign dst_o    = q.dst;
    assign dend_o   = q.dend;

endmodule

// File: rtl/ndr_serial.sv
module ndr_serial
    import ndr_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             abort_i,
    input  logic [4:0]       mode_i,
    input  logic [7:0]       opc_i,
    input  logic [FA_W-1:0]  faddr_i,
    input  logic [LEN_W-1:0] nbytes_i,
    input  logic [3:0]       io_in,
    output logic             sck_o,
    output logic             cs_n_o,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic             byte_vld_o,
    output logic [7:0]       byte_dat_o
);

    typedef struct packed {
        phase_e            ph;
        logic              sck;
        logic [SR_W-1:0]   sr;
        logic [5:0]        cnt;
        logic [5:0]        aclk;
        logic [1:0]        al;
        logic [1:0]        dl;
        logic [3:0]        dummy;
        logic [7:0]        inb;
        logic [3:0]        nbits;
        logic [LEN_W-1:0]  rem;
    } ser_t;

    ser_t       q, d;
    logic [1:0] l_al, l_dl;
    logic [7:0] nxt_inb;
    logic [3:0] nxt_bits;

    assign l_dl = data_lanes_log(mode_i);
    assign l_al = addr_lanes_log(mode_i);

    always_comb begin
        d          = q;
        byte_vld_o = 1'b0;
        byte_dat_o = q.inb;
        case (q.dl)
            2'd0:    nxt_inb = {q.inb[6:0], io_in[1]};
            2'd1:    nxt_inb = {q.inb[5:0], io_in[1:0]};
            default: nxt_inb = {q.inb[3:0], io_in};
        endcase
        nxt_bits = q.nbits + (4'd1 << q.dl);

        if (abort_i) begin
            d.ph  = PH_IDLE;
            d.sck = 1'b0;
        end else if (launch_i) begin
            d.ph    = PH_CMD;
            d.sck   = 1'b0;
            d.sr    = mode_i[BM_WIDE_AD] ? {opc_i, faddr_i}
                                         : {opc_i, faddr_i[23:0], 8'h00};
            d.cnt   = 6'd8;
            d.al    = l_al;
            d.dl    = l_dl;
            d.aclk  = (mode_i[BM_WIDE_AD] ? 6'd32 : 6'd24) >> l_al;
            d.dummy = dummy_clocks(l_dl, l_al, opc_i);
            d.inb   = '0;
            d.nbits = '0;
            d.rem   = nbytes_i;
        end else if (q.ph != PH_IDLE) begin
            d.sck = ~q.sck;
            if (!q.sck) begin
                // rising serial edge: sample
                if (q.ph == PH_DATA) begin
                    d.inb = nxt_inb;
                    if (nxt_bits == 4'd8) begin
                        byte_vld_o = 1'b1;
                        byte_dat_o = nxt_inb;
                        d.nbits    = '0;
                        d.rem      = q.rem - LEN_W'(1);
                    end else begin
                        d.nbits = nxt_bits;
                    end
                end
            end else begin
                // falling serial edge: advance
                d.cnt = q.cnt - 6'd1;
                case (q.ph)
                    PH_CMD: begin
                        d.sr = q.sr << 1;
                        if (q.cnt == 6'd1) begin
                            d.ph  = PH_ADDR;
                            d.cnt = q.aclk;
                        end
                    end
                    PH_ADDR: begin
                        case (q.al)
                            2'd0:    d.sr = q.sr << 1;
                            2'd1:    d.sr = q.sr << 2;
                            default: d.sr = q.sr << 4;
                        endcase
                        if (q.cnt == 6'd1) begin
                            if (q.dummy != 4'd0) begin
                                d.ph  = PH_DUMMY;
                                d.cnt = {2'b00, q.dummy};
                            end else begin
                                d.ph = PH_DATA;
                            end
                        end
                    end
                    PH_DUMMY: if (q.cnt == 6'd1) d.ph = PH_DATA;
                    PH_DATA:  if (q.rem == '0) d.ph = PH_IDLE;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (q.ph == PH_CMD) begin
            io_out[0] = q.sr[SR_W-1];
            io_oe     = 4'b0001;
        end else if (q.ph == PH_ADDR) begin
            case (q.al)
                2'd0: begin
                    io_out[0] = q.sr[SR_W-1];
                    io_oe     = 4'b0001;
                end
                2'd1: begin
                    io_out[1:0] = q.sr[SR_W-1 -: 2];
                    io_oe       = 4'b0011;
                end
                default: begin
                    io_out = q.sr[SR_W-1 -: 4];
                    io_oe  = 4'b1111;
                end
            endcase
        end
    end

    assign sck_o  = q.sck;
    assign cs_n_o = (q.ph == PH_IDLE);

endmodule

// File: rtl/ndr_pack.sv
module ndr_pack #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch_i,
    input  logic                    abort_i,
    input  logic [ADDR_W-1:0]       dst_i,
    input  logic [ADDR_W-1:0]       dend_i,
    input  logic                    byte_vld_i,
    input  logic [7:0]              byte_dat_i,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BEAT_BYTES*8-1:0] mem_wdata,
    output logic                    done_o
);

    localparam int BEAT_W = BEAT_BYTES * 8;
    localparam int IDX_W  = $clog2(BEAT_BYTES);

    typedef struct packed {
        logic [BEAT_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] lim;
        logic              we;
        logic [ADDR_W-1:0] wa;
        logic [BEAT_W-1:0] wd;
        logic              last;
    } pk_t;

    pk_t               q, d;
    logic [BEAT_W-1:0] merged;

    always_comb begin
        merged = q.acc;
        for (int k = 0; k < BEAT_BYTES; k++) begin
            if (q.idx == IDX_W'(k)) merged[k*8 +: 8] = byte_dat_i;
        end
    end

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.last = 1'b0;
        if (abort_i) begin
            d.idx = '0;
        end else if (launch_i) begin
            d.nxt = dst_i;
            d.lim = dend_i;
            d.idx = '0;
        end else if (byte_vld_i) begin
            d.acc = merged;
            if (q.idx == IDX_W'(BEAT_BYTES - 1)) begin
                d.we   = 1'b1;
                d.wa   = q.nxt;
                d.wd   = merged;
                d.nxt  = q.nxt + ADDR_W'(BEAT_BYTES);
                d.last = (q.nxt + ADDR_W'(BEAT_BYTES)) == q.lim;
                d.idx  = '0;
            end else begin
                d.idx = q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.wa;
    assign mem_wdata = q.wd;
    assign done_o    = q.we & q.last;

endmodule

// File: rtl/nor_dma_reader.sv
module nor_dma_reader
    import ndr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [7:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    irq,
    output logic                    spi_sck,
    output logic                    spi_cs_n,
    output logic [3:0]              spi_io_out,
    output logic [3:0]              spi_io_oe,
    input  logic [3:0]              spi_io_in,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BEAT_BYTES*8-1:0] mem_wdata
);

    logic              launch_w, abort_w, busy_w, done_w;
    logic [4:0]        mode_w;
    logic [7:0]        opc_w;
    logic [FA_W-1:0]   faddr_w;
    logic [ADDR_W-1:0] dst_w, dend_w, len_w;
    logic              bvld_w;
    logic [7:0]        bdat_w;

    assign len_w = dend_w - dst_w;

    ndr_regs #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done_i(done_w),
        .launch_o(launch_w), .abort_o(abort_w), .busy_o(busy_w), .irq_o(irq),
        .mode_o(mode_w), .opc_o(opc_w), .faddr_o(faddr_w),
        .dst_o(dst_w), .dend_o(dend_w)
    );

    ndr_serial #(.LEN_W(ADDR_W)) u_serial (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch_w), .abort_i(abort_w),
        .mode_i(mode_w), .opc_i(opc_w), .faddr_i(faddr_w), .nbytes_i(len_w),
        .io_in(spi_io_in),
        .sck_o(spi_sck), .cs_n_o(spi_cs_n),
        .io_out(spi_io_out), .io_oe(spi_io_oe),
        .byte_vld_o(bvld_w), .byte_dat_o(bdat_w)
    );

    ndr_pack #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch_w), .abort_i(abort_w),
        .dst_i(dst_w), .dend_i(dend_w),
        .byte_vld_i(bvld_w), .byte_dat_i(bdat_w),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done_o(done_w)
    );

endmodule

// File: rtl/ndr_checker.sv
module ndr_checker
    import ndr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              spi_sck,
    input logic              spi_cs_n,
    input logic [3:0]        spi_io_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy
);

    localparam int LSB_W = $clog2(BEAT_BYTES);

    p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_drive_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|spi_io_oe) |-> !spi_cs_n);

    p_beat_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[LSB_W-1:0] == '0));

    p_beat_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !spi_cs_n);

    p_frame_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CTRL && reg_wdata[CTRL_ABORT])
        |=> (spi_cs_n && !busy && !mem_we));

endmodule

bind nor_dma_reader ndr_checker #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_oe(spi_io_oe),
    .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy_w)
);

// File: tb/nor_dma_reader_bench.sv
`timescale 1ns/1ps
module nor_dma_reader_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq, spi_sck, spi_cs_n, mem_we;
    logic [3:0]   spi_io_out, spi_io_oe;
    logic [3:0]   spi_io_in = '0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;

    always #2.5 clk = ~clk;

    nor_dma_reader u_nor_dma_reader (.*);

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model configuration (set by the bench from R3/R4/R5)
    int          m_dl = 1, m_al = 1, m_ab = 3, m_pre = 40;
    logic [31:0] m_fa = '0;
    int          cs_falls = 0, seen = 0, r = 0;
    logic [7:0]  cap_cmd = '0;
    logic [31:0] cap_addr = '0;

    function automatic logic [7:0] fb(input logic [31:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
    endfunction

    always @(negedge spi_cs_n) cs_falls++;

    always @(posedge spi_sck) begin
        if (seen != cs_falls) begin
            seen = cs_falls; r = 0; cap_cmd = '0; cap_addr = '0;
        end
        r++;
        if (r <= 8) cap_cmd = {cap_cmd[6:0], spi_io_out[0]};
        else if (r <= 8 + m_ab * 8 / m_al) begin
            if (m_al == 1)      cap_addr = {cap_addr[30:0], spi_io_out[0]};
            else if (m_al == 2) cap_addr = {cap_addr[29:0], spi_io_out[1:0]};
            else                cap_addr = {cap_addr[27:0], spi_io_out};
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && r >= m_pre) begin
            int j;
            logic [7:0] b;
            j = r - m_pre;
            b = fb(m_fa + 32'(j * m_dl / 8));
            if (m_dl == 1)      spi_io_in = {2'b00, b[7 - (j % 8)], 1'b0};
            else if (m_dl == 2) spi_io_in = {2'b00, b[7 - 2*(j % 4)], b[6 - 2*(j % 4)]};
            else                spi_io_in = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
    end

    int           mcnt = 0;
    logic [31:0]  maddr [16];
    logic [127:0] mdata [16];
    always @(negedge clk) begin
        if (mem_we) begin
            if (mcnt < 16) begin
                maddr[mcnt] = mem_addr;
                mdata[mcnt] = mem_wdata;
            end
            mcnt++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // program the model from the mode bits, following R4 and R5
    task automatic set_model(input logic [4:0] mode, input logic [7:0] opc,
                             input logic [31:0] fa);
        int dmy;
        m_dl = mode[2] ? 4 : (mode[0] ? 2 : 1);
        m_al = mode[2] ? (mode[3] ? 4 : 1) : (mode[0] ? (mode[1] ? 2 : 1) : 1);
        m_ab = mode[4] ? 4 : 3;
        if (m_dl > 1) dmy = (m_al == 1) ? 8 : ((m_al == 2) ? 4 : 6);
        else          dmy = (opc == 8'h0B) ? 8 : 0;
        m_pre = 8 + m_ab * 8 / m_al + dmy;
        m_fa = fa;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 6000 && !irq; i++) @(negedge clk);
    endtask

    // {mode, opcode, flash address, destination, beats}
    localparam logic [84:0] VEC [8] = '{
        {5'h00, 8'h03, 32'h0000_0120, 32'h0000_1000, 8'd1},
        {5'h00, 8'h0B, 32'h00AB_3450, 32'h0000_2000, 8'd2},
        {5'h01, 8'h3B, 32'h0000_0010, 32'h0000_3000, 8'd1},
        {5'h03, 8'hBB, 32'h0001_2340, 32'h0000_3400, 8'd2},
        {5'h04, 8'h6B, 32'h0000_0500, 32'h0000_5000, 8'd1},
        {5'h0C, 8'hEB, 32'h0000_7770, 32'h0000_6000, 8'd3},
        {5'h1C, 8'hEC, 32'h0123_4560, 32'h0000_7000, 8'd2},
        {5'h10, 8'h13, 32'h0200_0030, 32'h0000_8000, 8'd1}
    };

    logic [31:0] v;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(spi_cs_n && !spi_sck && spi_io_oe == 0 && !irq && !mem_we,
            "R1 reset pins", {spi_cs_n, spi_sck, spi_io_oe, irq, mem_we}, 8'h80);

        // R1: alignment of address registers
        wr(8'h10, 32'h0000_1237); rd(8'h10, v);
        chk(v == 32'h0000_1230, "R1 dst align", v, 32'h1230);
        wr(8'h0C, 32'h1234_5678); rd(8'h0C, v);
        chk(v == 32'h1234_5670, "R1 flash addr align", v, 32'h1234_5670);

        // vector table: R2..R8
        for (int i = 0; i < 8; i++) begin
            logic [4:0]  mode;
            logic [7:0]  opc;
            logic [31:0] fa, dst;
            int          nb, bad, mc0;
            mode = VEC[i][84:80]; opc = VEC[i][79:72]; fa = VEC[i][71:40];
            dst = VEC[i][39:8]; nb = int'(VEC[i][7:0]);
            set_model(mode, opc, fa);
            wr(8'h04, 32'(mode)); wr(8'h08, 32'(opc)); wr(8'h0C, fa);
            wr(8'h10, dst); wr(8'h14, dst + 32'(nb * 16));
            wr(8'h1C, 32'h80); wr(8'h18, 32'h80);
            mc0 = mcnt;
            wr(8'h00, 32'h1);
            rd(8'h00, v);
            chk(v[0] == 1'b1, "R2 go reads busy", v, 1);
            wait_irq();
            chk(irq == 1'b1, "R8 irq on done", irq, 1);
            repeat (2) @(negedge clk);
            rd(8'h00, v); chk(v[0] == 1'b0, "R2 go cleared", v, 0);
            rd(8'h18, v); chk(v[7] == 1'b1, "R7 done status", v, 32'h80);
            chk(cap_cmd == opc, "R3 opcode", cap_cmd, opc);
            if (m_ab == 4) chk(cap_addr == fa, "R3 address", cap_addr, fa);
            else chk(cap_addr[23:0] == fa[23:0], "R3 address", cap_addr[23:0], fa[23:0]);
            chk(mcnt - mc0 == nb, "R6 beat count", mcnt - mc0, nb);
            bad = 0;
            for (int b = 0; b < nb; b++) begin
                logic [127:0] e;
                for (int k = 0; k < 16; k++) e[k*8 +: 8] = fb(fa + 32'(b * 16 + k));
                if (maddr[mc0 + b] != dst + 32'(b * 16) || mdata[mc0 + b] != e) begin
                    bad++;
                    chk(1'b0, "R4 R5 R6 beat", mdata[mc0 + b], e);
                end
            end
            chk(bad == 0, "R4 R5 beat data", bad, 0);
            wr(8'h18, 32'h0); rd(8'h18, v);
            chk(v[7] == 1'b1, "R7 write zero keeps", v, 32'h80);
            wr(8'h18, 32'h80); rd(8'h18, v);
            chk(v[7] == 1'b0, "R7 write one clears", v, 0);
        end

        // R9: zero-length and negative-length requests
        begin
            int cf, mc;
            cf = cs_falls; mc = mcnt;
            wr(8'h1C, 32'h0);
            wr(8'h10, 32'h4000); wr(8'h14, 32'h4000);
            wr(8'h00, 32'h1);
            repeat (3) @(negedge clk);
            rd(8'h18, v); chk(v[7] == 1'b1, "R9 empty sets status", v, 32'h80);
            rd(8'h00, v); chk(v[0] == 1'b0, "R9 empty not busy", v, 0);
            chk(cs_falls == cf && mcnt == mc, "R9 no flash or memory", cs_falls - cf + mcnt - mc, 0);
            // R8: masking
            chk(irq == 1'b0, "R8 masked irq", irq, 0);
            wr(8'h1C, 32'h80);
            chk(irq == 1'b1, "R8 enabled irq", irq, 1);
            wr(8'h18, 32'h80);
            chk(irq == 1'b0, "R8 cleared irq", irq, 0);
            wr(8'h14, 32'h3000); wr(8'h00, 32'h1);
            repeat (3) @(negedge clk);
            rd(8'h18, v); chk(v[7] == 1'b1, "R9 reversed sets status", v, 32'h80);
            chk(cs_falls == cf && mcnt == mc, "R9 reversed no access", cs_falls - cf + mcnt - mc, 0);
            wr(8'h18, 32'h80);
        end

        // R10: abort in the middle of a long transfer, then a clean transfer
        begin
            int mc;
            set_model(5'h00, 8'h03, 32'h0000_0800);
            wr(8'h04, 32'h0); wr(8'h08, 32'h03); wr(8'h0C, 32'h800);
            wr(8'h10, 32'h9000); wr(8'h14, 32'h9040);
            wr(8'h00, 32'h1);
            repeat (300) @(negedge clk);
            wr(8'h00, 32'h2);
            chk(spi_cs_n == 1'b1, "R10 chip released", spi_cs_n, 1);
            rd(8'h00, v); chk(v[0] == 1'b0, "R10 not busy", v, 0);
            mc = mcnt;
            repeat (400) @(negedge clk);
            chk(mcnt == mc, "R10 no more beats", mcnt - mc, 0);
            rd(8'h18, v); chk(v[7] == 1'b0, "R10 no status", v, 0);

            set_model(5'h0C, 8'hEB, 32'h0000_0A00);
            wr(8'h04, 32'h0C); wr(8'h08, 32'hEB); wr(8'h0C, 32'hA00);
            wr(8'h10, 32'hA000); wr(8'h14, 32'hA010);
            mc = mcnt;
            wr(8'h00, 32'h1);
            wait_irq();
            repeat (2) @(negedge clk);
            begin
                logic [127:0] e;
                for (int k = 0; k < 16; k++) e[k*8 +: 8] = fb(32'hA00 + 32'(k));
                chk(mcnt - mc == 1 && mdata[mc] == e, "R10 recovery beat", mdata[mc], e);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule